// File: doc/BRIEF.md
# Time-Slot Route Sequencer

This block tells a time-division multiplexed framer which internal serial consumer owns each time slot. Routing is held as a short run-length list. Each entry pairs a slot count with a destination code, and the entries are walked in order from the start of every frame. Once per slot, the block reports the destination code of that slot and a flag that says whether the slot is routed at all.

There are two independent walkers, index 0 for transmit and index 1 for receive. Each has its own list, its own slot strobe and its own frame-start input, and each owns two banks of list storage. While the sequencer is disabled, a write goes straight into the live bank. While it is enabled, a write lands in the standby bank, and that bank goes live at the direction's next frame start. This lets the routing change on a clean frame boundary.

Top module: `route_seq`

## Requirements
- R1: After reset, every `sel` field is 0, every `valid` bit is 0, bank 0 is live for both directions, and all stored entries are cleared.
- R2: Destination code 0 means the slot is unused, and the block gives `valid`=0 with `sel`=0. A nonzero code is presented on `sel` with `valid`=1.
- R3: A slot is a cycle with `slot_stb[d]` high. Slot 0 of a frame is the strobe that carries `frame_start[d]` high. Entries cover consecutive slots in list order, and the result appears on the outputs in the cycle after the strobe. The outputs hold until the next strobe of that direction.
- R4: An entry whose last flag is set ends the list. Once its slots are used up, the remaining slots are unused until the next frame start.
- R5: An entry with count 0 takes up no slot and is skipped within the same strobe. A count-0 entry whose last flag is set ends the list at that point.
- R6: Field d of the outputs (d=0 transmit, d=1 receive) depends only on list d, `slot_stb[d]` and `frame_start[d]`. `wr_dir` selects the list that a write goes to.
- R7: A frame start always restarts the walk at entry 0, even in the middle of a list.
- R8: A write made while `enable` is high goes to the standby bank. It does not change the frame in progress. The standby bank goes live at the next frame start of that direction.
- R9: While `enable` is low, the outputs are 0 from the next clock edge on and strobes are ignored. After `enable` rises again, walking resumes only at a frame start. A write made while disabled goes to the live bank.
- R10: A list with no last flag ends after entry DEPTH-1 (entry 15 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Sequencer enable |
| slot_stb | input | 2 | Per-direction slot strobe (0 transmit, 1 receive) |
| frame_start | input | 2 | Per-direction frame start, qualified by the same-cycle strobe |
| wr_en | input | 1 | List write strobe |
| wr_dir | input | 1 | Direction the write targets |
| wr_addr | input | $clog2(DEPTH) | Entry index |
| wr_count | input | COUNT_W | Slot count of the entry |
| wr_dest | input | DEST_W | Destination code of the entry, 0 = unused |
| wr_last | input | 1 | Marks the entry as the end of the list |
| sel | output | 2*DEST_W | Destination code per direction, direction d in bits [d*DEST_W +: DEST_W] |
| valid | output | 2 | Slot routed to a consumer, per direction |

## Verification
The hardest case to reach is a bank swap that happens while a frame is still in progress. The stimulus first programs a list while the block is disabled and starts a frame. It then writes a replacement list with the block enabled and keeps strobing the old frame, to show that the old routing is still in force. A fresh frame start then brings in the new list, and that list contains a zero-count last entry. The same strobe sequences also interleave transmit slots with a full receive frame, which shows that the two walkers share no state.

// File: rtl/route_seq_pkg.sv
package route_seq_pkg;
  localparam int NUM_DIR = 2;
  localparam int DIR_TX  = 0;
  localparam int DIR_RX  = 1;
  localparam int DIR_W   = $clog2(NUM_DIR);
endpackage

// File: rtl/route_table.sv
module route_table #(
  parameter int DEPTH   = 16,
  parameter int COUNT_W = 8,
  parameter int DEST_W  = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       enable,
  input  logic                       stb,
  input  logic                       fs,
  input  logic                       wr_en,
  input  logic [$clog2(DEPTH)-1:0]   wr_addr,
  input  logic [COUNT_W-1:0]         wr_count,
  input  logic [DEST_W-1:0]          wr_dest,
  input  logic                       wr_last,
  output logic [DEPTH*COUNT_W-1:0]   cnt_flat,
  output logic [DEPTH*DEST_W-1:0]    dest_flat,
  output logic [DEPTH-1:0]           last_vec
);
  localparam int AW    = $clog2(DEPTH);
  localparam int SLOTS = 2 * DEPTH;

  logic [COUNT_W-1:0] cnt_mem  [SLOTS];
  logic [DEST_W-1:0]  dest_mem [SLOTS];
  logic               last_mem [SLOTS];
  logic               bank_q, pending_q;
  logic               swap, view_bank, wr_bank;

  assign swap      = enable && stb && fs && pending_q;
  assign view_bank = bank_q ^ swap;
  assign wr_bank   = enable ? ~bank_q : bank_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_q    <= 1'b0;
      pending_q <= 1'b0;
      for (int i = 0; i < SLOTS; i++) begin
        cnt_mem[i]  <= '0;
        dest_mem[i] <= '0;
        last_mem[i] <= 1'b0;
      end
    end else begin
      if (wr_en) begin
        cnt_mem[{wr_bank, wr_addr}]  <= wr_count;
        dest_mem[{wr_bank, wr_addr}] <= wr_dest;
        last_mem[{wr_bank, wr_addr}] <= wr_last;
        if (enable) pending_q <= 1'b1;
      end
      if (swap) begin
        bank_q    <= ~bank_q;
        pending_q <= 1'b0;
      end
    end
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_view
    assign cnt_flat[e*COUNT_W +: COUNT_W] = cnt_mem[{view_bank, AW'(e)}];
    assign dest_flat[e*DEST_W +: DEST_W]  = dest_mem[{view_bank, AW'(e)}];
    assign last_vec[e]                    = last_mem[{view_bank, AW'(e)}];
  end
endmodule

// File: rtl/route_walker.sv
module route_walker #(
  parameter int DEPTH   = 16,
  parameter int COUNT_W = 8,
  parameter int DEST_W  = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       enable,
  input  logic                       stb,
  input  logic                       fs,
  input  logic [DEPTH*COUNT_W-1:0]   cnt_flat,
  input  logic [DEPTH*DEST_W-1:0]    dest_flat,
  input  logic [DEPTH-1:0]           last_vec,
  output logic [DEST_W-1:0]          sel,
  output logic                       valid
);
  localparam int AW = $clog2(DEPTH);

  logic [AW-1:0]      idx_q;
  logic [COUNT_W-1:0] rem_q;
  logic               done_q;

  logic [AW:0]        start_ix;
  logic               found, stop, may_fetch, need_fetch;
  logic [AW-1:0]      hit;
  logic [COUNT_W-1:0] hit_cnt;
  logic [DEST_W-1:0]  hit_dest, cur_dest;

  assign start_ix   = fs ? '0 : ({1'b0, idx_q} + 1'b1);
  assign may_fetch  = fs || (!last_vec[idx_q] && (idx_q != AW'(DEPTH - 1)));
  assign need_fetch = fs || (!done_q && (rem_q == '0));
  assign hit_cnt    = cnt_flat[hit*COUNT_W +: COUNT_W];
  assign hit_dest   = dest_flat[hit*DEST_W +: DEST_W];
  assign cur_dest   = dest_flat[idx_q*DEST_W +: DEST_W];

  // first nonzero-count entry at or after start_ix, not crossing a last flag
  always_comb begin
    found = 1'b0;
    stop  = 1'b0;
    hit   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!found && !stop && ((AW+1)'(i) >= start_ix)) begin
        if (cnt_flat[i*COUNT_W +: COUNT_W] != '0) begin
          found = 1'b1;
          hit   = AW'(i);
        end else if (last_vec[i]) begin
          stop = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q  <= '0;
      rem_q  <= '0;
      done_q <= 1'b1;
      sel    <= '0;
      valid  <= 1'b0;
    end else if (!enable) begin
      done_q <= 1'b1;
      sel    <= '0;
      valid  <= 1'b0;
    end else if (stb) begin
      if (need_fetch) begin
        if (may_fetch && found) begin
          idx_q  <= hit;
          rem_q  <= hit_cnt - 1'b1;
          done_q <= 1'b0;
          sel    <= hit_dest;
          valid  <= (hit_dest != '0);
        end else begin
          done_q <= 1'b1;
          sel    <= '0;
          valid  <= 1'b0;
        end
      end else if (done_q) begin
        sel   <= '0;
        valid <= 1'b0;
      end else begin
        rem_q <= rem_q - 1'b1;
        sel   <= cur_dest;
        valid <= (cur_dest != '0);
      end
    end
  end
endmodule

// File: rtl/route_seq.sv
module route_seq
  import route_seq_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int COUNT_W = 8,
  parameter int DEST_W  = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       enable,
  input  logic [1:0]                 slot_stb,
  input  logic [1:0]                 frame_start,
  input  logic                       wr_en,
  input  logic                       wr_dir,
  input  logic [$clog2(DEPTH)-1:0]   wr_addr,
  input  logic [COUNT_W-1:0]         wr_count,
  input  logic [DEST_W-1:0]          wr_dest,
  input  logic                       wr_last,
  output logic [2*DEST_W-1:0]        sel,
  output logic [1:0]                 valid
);
  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    logic [DEPTH*COUNT_W-1:0] cnt_flat;
    logic [DEPTH*DEST_W-1:0]  dest_flat;
    logic [DEPTH-1:0]         last_vec;

    route_table #(.DEPTH(DEPTH), .COUNT_W(COUNT_W), .DEST_W(DEST_W)) u_tab (
      .clk(clk), .rst(rst), .enable(enable),
      .stb(slot_stb[d]), .fs(frame_start[d]),
      .wr_en(wr_en && (wr_dir == DIR_W'(d))),
      .wr_addr(wr_addr), .wr_count(wr_count), .wr_dest(wr_dest), .wr_last(wr_last),
      .cnt_flat(cnt_flat), .dest_flat(dest_flat), .last_vec(last_vec)
    );

    route_walker #(.DEPTH(DEPTH), .COUNT_W(COUNT_W), .DEST_W(DEST_W)) u_walk (
      .clk(clk), .rst(rst), .enable(enable),
      .stb(slot_stb[d]), .fs(frame_start[d]),
      .cnt_flat(cnt_flat), .dest_flat(dest_flat), .last_vec(last_vec),
      .sel(sel[d*DEST_W +: DEST_W]), .valid(valid[d])
    );
  end
endmodule

// File: rtl/route_seq_chk.sv
module route_seq_chk #(
  parameter int DEST_W = 3
) (
  input logic                clk,
  input logic                rst,
  input logic                enable,
  input logic [1:0]          slot_stb,
  input logic [2*DEST_W-1:0] sel,
  input logic [1:0]          valid
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (valid == '0 && sel == '0));

  assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (valid == '0 && sel == '0));

  for (genvar d = 0; d < 2; d++) begin : g_d
    assert_hold_between_R3: assert property (@(posedge clk) disable iff (rst)
      (enable && !slot_stb[d]) |=>
        ($stable(sel[d*DEST_W +: DEST_W]) && $stable(valid[d])));

    assert_code_flag_R2: assert property (@(posedge clk) disable iff (rst)
      valid[d] == (sel[d*DEST_W +: DEST_W] != '0));
  end
endmodule

bind route_seq route_seq_chk #(.DEST_W(DEST_W)) u_chk (
  .clk(clk), .rst(rst), .enable(enable), .slot_stb(slot_stb),
  .sel(sel), .valid(valid)
);

// File: tb/route_seq_test.sv
module route_seq_test;
  localparam int DEPTH = 16;
  localparam int CW    = 8;
  localparam int DW    = 3;

  logic clk = 1'b0, rst = 1'b1, enable = 1'b0;
  logic [1:0] slot_stb = '0, frame_start = '0;
  logic wr_en = 1'b0, wr_dir = 1'b0, wr_last = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [CW-1:0] wr_count = '0;
  logic [DW-1:0] wr_dest = '0;
  logic [2*DW-1:0] sel;
  logic [1:0] valid;

  route_seq #(.DEPTH(DEPTH), .COUNT_W(CW), .DEST_W(DW)) uut (
    .clk(clk), .rst(rst), .enable(enable), .slot_stb(slot_stb),
    .frame_start(frame_start), .wr_en(wr_en), .wr_dir(wr_dir),
    .wr_addr(wr_addr), .wr_count(wr_count), .wr_dest(wr_dest),
    .wr_last(wr_last), .sel(sel), .valid(valid)
  );

  always #2 clk = ~clk;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  typedef struct { int d; int dest; string tag; } exp_t;
  exp_t q[$];

  // live list per direction (model) and staged writes
  int  mc[2][DEPTH], md[2][DEPTH];
  bit  ml[2][DEPTH];
  int  sc[2][DEPTH], sd[2][DEPTH];
  bit  sl[2][DEPTH];

  task automatic check(bit ok, string tag, int act, int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic wr(int d, int a, int c, int de, bit l);
    @(negedge clk);
    wr_en = 1; wr_dir = d[0]; wr_addr = a[3:0]; wr_count = c[CW-1:0];
    wr_dest = de[DW-1:0]; wr_last = l;
    @(posedge clk); #1 wr_en = 0;
    sc[d][a] = c; sd[d][a] = de; sl[d][a] = l;
  endtask

  task automatic go_live(int d);
    for (int e = 0; e < DEPTH; e++) begin
      mc[d][e] = sc[d][e]; md[d][e] = sd[d][e]; ml[d][e] = sl[d][e];
      sc[d][e] = 0; sd[d][e] = 0; sl[d][e] = 0;
    end
  endtask

  function automatic int slot_dest(int d, int n);
    int pos = 0;
    for (int e = 0; e < DEPTH; e++) begin
      if (mc[d][e] != 0) begin
        if (n < pos + mc[d][e]) return md[d][e];
        pos += mc[d][e];
      end
      if (ml[d][e]) return 0;
    end
    return 0;
  endfunction

  task automatic do_slot(int d, bit fs, int dest, string tag);
    exp_t x;
    x.d = d; x.dest = dest; x.tag = tag;
    q.push_back(x);
    @(negedge clk);
    slot_stb[d] = 1'b1; frame_start[d] = fs;
    @(posedge clk); #1 slot_stb = '0; frame_start = '0;
    @(negedge clk);
  endtask

  task automatic run_slots(int d, int first, int cnt, bit fs_first, string tag);
    for (int i = 0; i < cnt; i++)
      do_slot(d, fs_first && (i == 0), slot_dest(d, first + i), tag);
  endtask

  // monitor: compare after each strobe edge
  initial begin
    forever begin
      logic [1:0] s;
      @(posedge clk);
      s = slot_stb;
      if (|s) begin
        @(negedge clk);
        for (int d = 0; d < 2; d++) begin
          if (s[d]) begin
            if (q.size() == 0) begin
              check(0, "scoreboard empty", d, -1);
            end else begin
              exp_t x;
              int a;
              x = q.pop_front();
              a = int'(sel[d*DW +: DW]);
              check(x.d == d && a == x.dest && valid[d] == (x.dest != 0),
                    x.tag, a * 2 + int'(valid[d]), x.dest * 2 + int'(x.dest != 0));
            end
          end
        end
      end
    end
  end

  initial begin
    #150000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int d = 0; d < 2; d++)
      for (int e = 0; e < DEPTH; e++) begin
        mc[d][e] = 0; md[d][e] = 0; ml[d][e] = 0;
        sc[d][e] = 0; sd[d][e] = 0; sl[d][e] = 0;
      end
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    check(sel == '0 && valid == '0, "R1 reset outputs", int'(sel), 0);

    // program both lists while disabled (live bank)
    wr(0, 0, 2, 0, 0); wr(0, 1, 3, 1, 0); wr(0, 2, 4, 0, 0); wr(0, 3, 2, 2, 1);
    go_live(0);
    wr(1, 0, 0, 7, 0); wr(1, 1, 1, 5, 0); wr(1, 2, 0, 7, 0); wr(1, 3, 2, 3, 1);
    wr(1, 4, 4, 6, 0);
    go_live(1);
    @(negedge clk); enable = 1;

    // R3 R2 R4: transmit frame, interleaved with R5 receive frame (R6)
    run_slots(0, 0, 5, 1, "R3 R2 tx run order");
    run_slots(1, 0, 6, 1, "R5 R6 rx zero-count skip");
    run_slots(0, 5, 8, 0, "R4 R6 tx tail and end");

    // R7: restart mid-list
    run_slots(0, 0, 3, 1, "R7 first part");
    run_slots(0, 0, 3, 1, "R7 restart at entry 0");

    // R8: write standby while enabled; old frame continues
    wr(0, 0, 1, 4, 0); wr(0, 1, 2, 6, 0); wr(0, 2, 0, 3, 1); wr(0, 3, 5, 1, 0);
    run_slots(0, 3, 6, 0, "R8 old list kept mid-frame");
    go_live(0);
    run_slots(0, 0, 5, 1, "R8 R5 new list after frame start");
    run_slots(0, 0, 2, 1, "R8 new list second frame");

    // R9: disable
    @(negedge clk); enable = 0;
    @(posedge clk); @(negedge clk);
    check(sel == '0 && valid == '0, "R9 outputs cleared on disable", int'(sel), 0);
    do_slot(0, 1, 0, "R9 strobe ignored while disabled");
    for (int e = 0; e < DEPTH; e++) wr(1, e, 1, (e % 7) + 1, 0);
    go_live(1);
    @(negedge clk); enable = 1;
    do_slot(1, 0, 0, "R9 no walk before frame start");

    // R10: full table without last flag
    run_slots(1, 0, 18, 1, "R10 end after final entry");

    repeat (4) @(negedge clk);
    check(q.size() == 0, "scoreboard drained", q.size(), 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule